// File: doc/BRIEF.md
# UART Modem Status Change Tracker

This block provides the modem status register of a 16550-compatible UART. It watches four active-low modem handshake inputs: carrier detect, ring indicator, data set ready and clear to send. It reports each one as an active-high level bit. For each line it also keeps a sticky change flag, which records a qualifying transition until software reads the register. While any flag is set and the modem-status interrupt is enabled, an interrupt request is raised.

In loopback mode the level bits come from four modem control output bits held elsewhere in the UART, not from the pins. Change detection then runs on those looped-back values, so software can test the whole change-and-interrupt path without external wiring.

Software reads the register through a small request/response port on a 32-bit peripheral bus. A request is a one-cycle `rd_valid` with a word address. The port never applies back-pressure: `rd_ready` is held high, so every cycle with `rd_valid` high is an accepted read. The response appears one cycle after acceptance as a single-cycle `rsp_valid` pulse carrying `rsp_data`. It cannot be stalled, so the consumer must take it in that cycle.

Top module: `uart_modem_status`

## Requirements
- R1: After reset every bit of the register reads 0 and `msi_irq` is 0, as long as all four pins are idle high.
- R2: An accepted read at address 0x18 returns, one cycle later, `rsp_valid`=1 with bits 31:8 equal to 0, bits 7:4 holding the levels and bits 3:0 holding the change flags. An accepted read at any other address returns all zeros and leaves the flags unchanged.
- R3: Outside loopback, the level bits are the complements of the pins after a two-flop synchronizer: bit 7 is `~dcd_n`, bit 6 is `~ri_n`, bit 5 is `~dsr_n` and bit 4 is `~cts_n`. A pin change is visible three clock edges after it occurs.
- R4: With `loop_en`=1, bit 7 equals `ctl_out2`, bit 6 equals `ctl_out1`, bit 5 equals `ctl_dtr` and bit 4 equals `ctl_rts`. The pins then have no effect on any bit.
- R5: Bit 3 (carrier detect), bit 1 (data set ready) and bit 0 (clear to send) set when their level changes in either direction.
- R6: Bit 2 sets only when `ri_n` goes from 0 to 1, which is a 1-to-0 fall of the bit 6 level. A 1-to-0 change of `ri_n` leaves bit 2 unchanged.
- R7: Once a change flag is set, it stays set until a read at 0x18 is accepted, even if its line returns to its earlier level.
- R8: A read accepted at 0x18 returns the flags as they were and clears them from the next cycle. A qualifying change on the same edge as the clear sets its flag again.
- R9: In loopback, toggling a control bit sets the matching change flag under the rules of R5 and R6.
- R10: `msi_irq` equals `msi_en` AND the OR of flag bits 3:0.
- R11: `rd_ready` is always 1, and `rsp_valid` pulses for exactly one cycle after each accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready (held high) |
| rd_addr | input | 8 | Byte address of the read request |
| rsp_valid | output | 1 | Read response valid, one-cycle pulse |
| rsp_data | output | 32 | Read response data |
| dcd_n | input | 1 | Carrier detect pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| loop_en | input | 1 | Loopback mode select |
| ctl_out2 | input | 1 | Control output OUT2, looped to bit 7 |
| ctl_out1 | input | 1 | Control output OUT1, looped to bit 6 |
| ctl_dtr | input | 1 | Control output DTR, looped to bit 5 |
| ctl_rts | input | 1 | Control output RTS, looped to bit 4 |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an 8-bit address and the register at 0x18. With only four lines, every ordered pair of 4-bit input patterns can be swept, 256 pairs from the pins and another 256 from the loopback controls. This covers every rising and falling edge on every line, in every combination with the other lines. Targeted sequences add the remaining cases: a line that changes and returns before the read, a change on the same edge as a read, reads at a wrong address, and pin activity during loopback.

// File: rtl/uart_msr_pkg.sv
package uart_msr_pkg;
  localparam int unsigned NLINES = 4;

  // Line index inside every 4-bit line vector
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  // Lines whose flag fires only on a falling level (rising active-low pin)
  localparam logic [NLINES-1:0] TRAIL_ONLY = 4'b0100;

  typedef struct packed {
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] chg;
  } msr_byte_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= {WIDTH{RST_VAL}};
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= {WIDTH{RST_VAL}};
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import uart_msr_pkg::*;
#(
  parameter int unsigned N = NLINES,
  parameter logic [N-1:0] TRAIL_MASK = TRAIL_ONLY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         clr,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (TRAIL_MASK[i]) begin : g_trail
      assign hit[i] = lvl_q[i] & ~src[i];
    end else begin : g_any
      assign hit[i] = lvl_q[i] ^ src[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q   <= '0;
      flags_q <= '0;
    end else begin
      lvl_q   <= src;
      flags_q <= (flags_q & ~{N{clr}}) | hit;
    end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R7

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((flags_q & ~($past(lvl_q) ^ lvl_q)) == '0)); // R8

  for (genvar i = 0; i < N; i++) begin : g_chk
    if (TRAIL_MASK[i]) begin : g_tr
      AST_TRAIL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[i]) |-> ($past(lvl_q[i]) && !lvl_q[i])); // R6
    end else begin : g_bo
      AST_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[i]) |-> ($past(lvl_q[i]) != lvl_q[i])); // R5
    end
  end
endmodule

// File: rtl/msr_read_port.sv
module msr_read_port
  import uart_msr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  msr_byte_t         msr,
  output logic              rd_ready,
  output logic              clr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int unsigned BYTE_W = $bits(msr_byte_t);

  logic accept;
  logic hit;

  assign rd_ready = 1'b1;
  assign accept   = rd_valid & rd_ready;
  assign hit      = accept & (rd_addr == OFFSET);
  assign clr      = hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_data  <= hit ? {{(DATA_W-BYTE_W){1'b0}}, msr} : '0;
    end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid)); // R11

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DATA_W-1:BYTE_W] == '0)); // R2
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_msr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_OFFSET  = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              dcd_n,
  input  logic              ri_n,
  input  logic              dsr_n,
  input  logic              cts_n,
  input  logic              loop_en,
  input  logic              ctl_out2,
  input  logic              ctl_out1,
  input  logic              ctl_dtr,
  input  logic              ctl_rts,
  input  logic              msi_en,
  output logic              msi_irq
);
  logic [NLINES-1:0] pins_n, pins_sync, ctl_vec, src, lvl, flags;
  logic              clr;
  msr_byte_t         msr;

  assign pins_n[LN_DCD] = dcd_n;
  assign pins_n[LN_RI]  = ri_n;
  assign pins_n[LN_DSR] = dsr_n;
  assign pins_n[LN_CTS] = cts_n;

  assign ctl_vec[LN_DCD] = ctl_out2;
  assign ctl_vec[LN_RI]  = ctl_out1;
  assign ctl_vec[LN_DSR] = ctl_dtr;
  assign ctl_vec[LN_CTS] = ctl_rts;

  msr_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(pins_sync)
  );

  assign src = loop_en ? ctl_vec : ~pins_sync;

  msr_delta #(.N(NLINES), .TRAIL_MASK(TRAIL_ONLY)) u_delta (
    .clk(clk), .rst_n(rst_n), .src(src), .clr(clr),
    .lvl_q(lvl), .flags_q(flags)
  );

  assign msr.lvl = lvl;
  assign msr.chg = flags;

  msr_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(ADDR_W'(REG_OFFSET))
  ) u_port (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .msr(msr), .rd_ready(rd_ready), .clr(clr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign msi_irq = msi_en & (|flags);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq |-> msi_en); // R10

  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_en) |-> (lvl == $past(ctl_vec))); // R4
endmodule

// File: tb/sim_uart_modem_status.sv
module sim_uart_modem_status;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [7:0]  rd_addr = 8'h00;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        dcd_n = 1'b1, ri_n = 1'b1, dsr_n = 1'b1, cts_n = 1'b1;
  logic        loop_en = 1'b0;
  logic        ctl_out2 = 1'b0, ctl_out1 = 1'b0, ctl_dtr = 1'b0, ctl_rts = 1'b0;
  logic        msi_en = 1'b0;
  logic        msi_irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_modem_status u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dcd_n(dcd_n), .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n),
    .loop_en(loop_en), .ctl_out2(ctl_out2), .ctl_out1(ctl_out1),
    .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .msi_en(msi_en), .msi_irq(msi_irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // p = {dcd_n, ri_n, dsr_n, cts_n}
  task automatic set_pins(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  // c = {out2, out1, dtr, rts}
  task automatic set_ctl(input logic [3:0] c);
    {ctl_out2, ctl_out1, ctl_dtr, ctl_rts} = c;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    rd_valid = 1'b1;
    rd_addr  = a;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    v = rsp_valid;
    d = rsp_data;
    check("R11 rsp_valid pulse", {31'b0, v}, 32'd1);
    @(negedge clk);
    check("R11 rsp_valid single cycle", {31'b0, rsp_valid}, 32'd0);
  endtask

  function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] chg;
    chg = a ^ b;
    return {chg[3], a[2] & ~b[2], chg[1], chg[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    logic [3:0]  fa;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", {31'b0, msi_irq}, 32'd0);
    check("R11 rd_ready", {31'b0, rd_ready}, 32'd1);
    do_read(8'h18, d, v);
    check("R1 register after reset", d, 32'h0);

    msi_en = 1'b1;

    // R3 R5 R6 R10: pin sweep over all ordered pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_pins(4'(a)); settle();
        do_read(8'h18, d, v);
        set_pins(4'(b)); settle();
        fa = exp_flags(~4'(a), ~4'(b));
        check("R10 irq from flags", {31'b0, msi_irq}, {31'b0, |fa});
        do_read(8'h18, d, v);
        check("R3 R5 R6 pin levels and flags", d, {24'b0, ~4'(b), fa});
        do_read(8'h18, d, v);
        check("R8 flags clear after read", d, {24'b0, ~4'(b), 4'h0});
      end
    end

    // R7 sticky: carrier detect goes active then back before the read
    set_pins(4'hF); settle(); do_read(8'h18, d, v);
    dcd_n = 1'b0; settle(); dcd_n = 1'b1; settle();
    msi_en = 1'b0; @(negedge clk);
    check("R10 irq gated by enable", {31'b0, msi_irq}, 32'd0);
    msi_en = 1'b1; @(negedge clk);
    check("R10 irq with enable", {31'b0, msi_irq}, 32'd1);
    // R2: other address returns zero and does not clear
    do_read(8'h14, d, v);
    check("R2 other address reads zero", d, 32'h0);
    do_read(8'h18, d, v);
    check("R7 flag held after round trip", d, 32'h0000_0008);
    check("R8 irq drops after read", {31'b0, msi_irq}, 32'd0);

    // R6: ri_n 1->0 alone sets nothing
    ri_n = 1'b0; settle();
    do_read(8'h18, d, v);
    check("R6 leading ring edge ignored", d, 32'h0000_0040);
    ri_n = 1'b1; settle();
    do_read(8'h18, d, v);
    check("R6 trailing ring edge flagged", d, 32'h0000_0004);

    // R4 R9: loopback sweep
    set_ctl(4'h0); loop_en = 1'b1; settle(); do_read(8'h18, d, v);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_ctl(4'(a)); settle();
        do_read(8'h18, d, v);
        set_ctl(4'(b)); settle();
        fa = exp_flags(4'(a), 4'(b));
        do_read(8'h18, d, v);
        check("R4 R9 loopback levels and flags", d, {24'b0, 4'(b), fa});
      end
    end

    // R4: pins ignored in loopback
    set_ctl(4'h5); settle(); do_read(8'h18, d, v);
    set_pins(4'h0); settle();
    do_read(8'h18, d, v);
    check("R4 pins ignored in loopback", d, 32'h0000_0050);
    set_pins(4'hF); settle();
    do_read(8'h18, d, v);
    check("R4 pins ignored in loopback again", d, 32'h0000_0050);

    // R8: change on the same edge as the clearing read
    set_ctl(4'h0); settle(); do_read(8'h18, d, v);
    rd_valid = 1'b1; rd_addr = 8'h18; ctl_rts = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
    check("R8 response holds old state", rsp_data, 32'h0);
    @(negedge clk);
    do_read(8'h18, d, v);
    check("R8 flag re-set on clear edge", d, 32'h0000_0011);
    do_read(8'h18, d, v);
    check("R8 flag cleared afterwards", d, 32'h0000_0010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule